// File: doc/BRIEF.md
# Programmable Memory Waveform Sequencer

This block produces the control waveforms for an external memory device from microcode that software loads. A 64-entry pattern store holds 32-bit words. Each word describes the chip-select line, the byte-select lines and one general-purpose line over the four quarter-phases (T1 to T4) of one bus cycle. The block runs on a clock at four times the bus rate. A 2-bit phase counter divides each bus cycle into its quarters, and every output is taken from a register, so the pins never glitch.

A host loads words through an address/data/write-enable port while the sequencer is idle. A start pulse with a word address begins a run. The sequencer then executes one word per bus cycle, four clocks per word, from consecutive addresses. It stops after the word whose top bit is set and pulses done.

The word's byte-select bits are combined with a lane mask. The mask is decoded from the port width, the transfer size and the two low address bits, and it is captured when the run starts. Lanes outside the mask stay inactive. The general-purpose line takes a 2-bit code at T1 and another at T3. Each code either forces a level or defers to a mode-register default bit.

Top module: `mem_wave_seq`

## Requirements
- R1: After reset, and whenever idle, the outputs are `cs_n`=1, `bs_n`=4'b1111 and `busy`=0. In those states `gpl` equals `gp_default` as sampled one clock earlier. `gpl` resets low and `done` resets low.
- R2: While running, word bit k (k=0..3) gives the `cs_n` level during phase T(k+1) of that word's bus cycle.
- R3: While running, word bit 4+k gives the level of every `bs_n` lane enabled by the lane mask during phase T(k+1). Lanes outside the mask are held at 1.
- R4: Word bits [9:8] give the `gpl` code applied at T1 and held through T2. Bits [11:10] give the code applied at T3 and held through T4. Code 2'b10 drives 0, code 2'b11 drives 1, and codes 2'b00 and 2'b01 take `gp_default`.
- R5: For a 32-bit port (`port_size`=2'b00) the lane mask depends on `xfer_size`. With 2'b01 (1 byte) it is the single lane numbered `addr_lo`. With 2'b10 (2 bytes) it is lanes 1:0 if `addr_lo[1]`=0 and lanes 3:2 otherwise. With 2'b00 or 2'b11 (4 bytes) it is all four lanes.
- R6: For a 16-bit port (`port_size`=2'b01) a 1-byte transfer enables lane 2 if `addr_lo[0]`=0 and lane 3 otherwise, and any other size enables lanes 3:2. For an 8-bit port (`port_size`=2'b10 or 2'b11) only lane 3 is enabled. The mask is captured at start and is not affected by later changes to these inputs.
- R7: A `start` pulse while idle raises `busy` at the next edge, and the first T1 levels of the word at `start_addr` appear at that same edge. Each word lasts exactly four clocks, the address then increments, and address 63 wraps to 0.
- R8: After T4 of a word with bit 31 set, the next edge returns the pins to idle levels, clears `busy` and raises `done` for exactly one clock.
- R9: While `busy`=1, host writes and `start` pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four times the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Pattern store write enable |
| host_addr | input | 6 | Pattern store write address |
| host_wdata | input | 32 | Pattern word to write |
| start | input | 1 | Begin a run (accepted when idle) |
| start_addr | input | 6 | First word of the run |
| gp_default | input | 1 | Mode-register default level for the general-purpose line |
| port_size | input | 2 | Port width: 00 = 32-bit, 01 = 16-bit, 1x = 8-bit |
| xfer_size | input | 2 | Transfer size: 01 = 1 byte, 10 = 2 bytes, 00/11 = 4 bytes |
| addr_lo | input | 2 | Two low address bits of the access |
| cs_n | output | 1 | Chip-select level |
| bs_n | output | 4 | Byte-select levels, one per lane |
| gpl | output | 1 | General-purpose line level |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-clock pulse when a run ends |

## Verification
If the start pulse is sampled at edge E, phase T(k+1) of the n-th word of the run is visible on the pins after edge E+4n+k. After the last word, `done` and the idle levels appear at edge E+4N, where N is the number of words executed. An idle `gpl` follows `gp_default` one edge after it changes. The bench drives inputs and samples outputs on falling edges, so each sample sits half a cycle after the edge that was due to produce it. It walks every phase of every word against these offsets. Writes and starts issued mid-run are placed in a known phase, so their absence of effect shows up on the very phases that follow.

// File: rtl/mws_pkg.sv
package mws_pkg;
  localparam int LANES   = 4;
  localparam int CS_LSB  = 0;
  localparam int BS_LSB  = 4;
  localparam int GPA_LSB = 8;
  localparam int GPB_LSB = 10;

  typedef logic [1:0] phase_t;

  // Lane enable decode: port width, transfer size, low address bits.
  function automatic logic [LANES-1:0] decode_lanes(input logic [1:0] psz,
                                                     input logic [1:0] xsz,
                                                     input logic [1:0] lo);
    logic [LANES-1:0] m;
    case (psz)
      2'b00: begin
        case (xsz)
          2'b01:   m = 4'b0001 << lo;
          2'b10:   m = lo[1] ? 4'b1100 : 4'b0011;
          default: m = 4'b1111;
        endcase
      end
      2'b01:   m = (xsz == 2'b01) ? (lo[0] ? 4'b1000 : 4'b0100) : 4'b1100;
      default: m = 4'b1000;
    endcase
    return m;
  endfunction

  // General-purpose code: 1x forces bit 0, 0x defers to the default.
  function automatic logic gp_level(input logic [1:0] code, input logic dflt);
    return code[1] ? code[0] : dflt;
  endfunction
endpackage

// File: rtl/mws_store.sv
module mws_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/mws_lane.sv
module mws_lane
  import mws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       port_size,
  input  logic [1:0]       xfer_size,
  input  logic [1:0]       addr_lo,
  output logic [LANES-1:0] mask_nxt,
  output logic [LANES-1:0] mask_q
);
  logic [LANES-1:0] dec;

  always_comb begin
    dec      = decode_lanes(port_size, xfer_size, addr_lo);
    mask_nxt = load ? dec : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (load) begin
      mask_q <= dec;
    end
  end
endmodule

// File: rtl/mws_ctl.sv
module mws_ctl
  import mws_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              rd_last,
  output logic              start_ok,
  output logic              busy,
  output phase_t            phase,
  output logic              busy_nxt,
  output phase_t            phase_nxt,
  output logic [ADDR_W-1:0] ptr_nxt,
  output logic              done
);
  logic [ADDR_W-1:0] ptr_q;
  logic              last_q;
  logic              done_nxt;

  assign start_ok = start & ~busy;

  always_comb begin
    busy_nxt  = busy;
    phase_nxt = phase;
    ptr_nxt   = ptr_q;
    done_nxt  = 1'b0;
    if (!busy) begin
      if (start_ok) begin
        busy_nxt  = 1'b1;
        phase_nxt = 2'd0;
        ptr_nxt   = start_addr;
      end
    end else if (phase != 2'd3) begin
      phase_nxt = phase + 2'd1;
    end else if (last_q) begin
      busy_nxt  = 1'b0;
      phase_nxt = 2'd0;
      done_nxt  = 1'b1;
    end else begin
      phase_nxt = 2'd0;
      ptr_nxt   = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 2'd0;
      ptr_q  <= '0;
      last_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      busy  <= busy_nxt;
      phase <= phase_nxt;
      ptr_q <= ptr_nxt;
      done  <= done_nxt;
      if (busy_nxt && (phase_nxt == 2'd0)) begin
        last_q <= rd_last;
      end
    end
  end
endmodule

// File: rtl/mws_pins.sv
module mws_pins
  import mws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_nxt,
  input  phase_t           phase_nxt,
  input  logic [3:0]       cs_bits,
  input  logic [3:0]       bs_bits,
  input  logic [1:0]       gp_code_a,
  input  logic [1:0]       gp_code_b,
  input  logic [LANES-1:0] mask_nxt,
  input  logic             gp_default,
  output logic             cs_n,
  output logic [LANES-1:0] bs_n,
  output logic             gpl
);
  logic             cs_d;
  logic [LANES-1:0] bs_d;
  logic             gp_d;
  logic             bs_lvl;

  assign bs_lvl = bs_bits[phase_nxt];
  assign cs_d   = busy_nxt ? cs_bits[phase_nxt] : 1'b1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bs_d[i] = (busy_nxt && mask_nxt[i]) ? bs_lvl : 1'b1;
  end

  always_comb begin
    gp_d = gpl;
    if (!busy_nxt) begin
      gp_d = gp_default;
    end else if (phase_nxt == 2'd0) begin
      gp_d = gp_level(gp_code_a, gp_default);
    end else if (phase_nxt == 2'd2) begin
      gp_d = gp_level(gp_code_b, gp_default);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= 1'b1;
      bs_n <= '1;
      gpl  <= 1'b0;
    end else begin
      cs_n <= cs_d;
      bs_n <= bs_d;
      gpl  <= gp_d;
    end
  end
endmodule

// File: rtl/mem_wave_seq.sv
module mem_wave_seq
  import mws_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              gp_default,
  input  logic [1:0]        port_size,
  input  logic [1:0]        xfer_size,
  input  logic [1:0]        addr_lo,
  output logic              cs_n,
  output logic [LANES-1:0]  bs_n,
  output logic              gpl,
  output logic              busy,
  output logic              done
);
  localparam int LAST_BIT = WORD_W - 1;

  logic              start_ok;
  logic              busy_nxt;
  phase_t            cur_ph;
  phase_t            phase_nxt;
  logic [ADDR_W-1:0] ptr_nxt;
  logic [WORD_W-1:0] rd_word;
  logic [LANES-1:0]  mask_nxt;
  logic [LANES-1:0]  lane_q;
  logic              unused_bits;

  assign unused_bits = ^rd_word[LAST_BIT-1:GPB_LSB+2];

  mws_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .wr_en   (host_we & ~busy),
    .wr_addr (host_addr),
    .wr_data (host_wdata),
    .rd_addr (ptr_nxt),
    .rd_data (rd_word)
  );

  mws_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .rd_last    (rd_word[LAST_BIT]),
    .start_ok   (start_ok),
    .busy       (busy),
    .phase      (cur_ph),
    .busy_nxt   (busy_nxt),
    .phase_nxt  (phase_nxt),
    .ptr_nxt    (ptr_nxt),
    .done       (done)
  );

  mws_lane u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .port_size (port_size),
    .xfer_size (xfer_size),
    .addr_lo   (addr_lo),
    .mask_nxt  (mask_nxt),
    .mask_q    (lane_q)
  );

  mws_pins u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_nxt   (busy_nxt),
    .phase_nxt  (phase_nxt),
    .cs_bits    (rd_word[CS_LSB+3:CS_LSB]),
    .bs_bits    (rd_word[BS_LSB+3:BS_LSB]),
    .gp_code_a  (rd_word[GPA_LSB+1:GPA_LSB]),
    .gp_code_b  (rd_word[GPB_LSB+1:GPB_LSB]),
    .mask_nxt   (mask_nxt),
    .gp_default (gp_default),
    .cs_n       (cs_n),
    .bs_n       (bs_n),
    .gpl        (gpl)
  );
endmodule

// File: rtl/mws_chk.sv
module mws_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       cs_n,
  input logic [3:0] bs_n,
  input logic       gpl,
  input logic [1:0] phase,
  input logic [3:0] mask
);
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && (bs_n == 4'hF))); // R1

  AST_BS_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((~bs_n & ~mask) == 4'h0)); // R3

  AST_GP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ((phase == 2'd1) || (phase == 2'd3))) |-> $stable(gpl)); // R4

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && (phase == 2'd0))); // R7

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (phase != 2'd0)) |-> (phase == $past(phase) + 2'd1)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
endmodule

bind mem_wave_seq mws_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .cs_n  (cs_n),
  .bs_n  (bs_n),
  .gpl   (gpl),
  .phase (cur_ph),
  .mask  (lane_q)
);

// File: tb/tb_mem_wave_seq.sv
`timescale 1ns/1ps
module tb_mem_wave_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [5:0]  host_addr;
  logic [31:0] host_wdata;
  logic        start;
  logic [5:0]  start_addr;
  logic        gp_default;
  logic [1:0]  port_size;
  logic [1:0]  xfer_size;
  logic [1:0]  addr_lo;
  logic        cs_n;
  logic [3:0]  bs_n;
  logic        gpl;
  logic        busy;
  logic        done;

  logic [31:0] model [64];
  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  mem_wave_seq dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .start(start), .start_addr(start_addr),
    .gp_default(gp_default), .port_size(port_size), .xfer_size(xfer_size),
    .addr_lo(addr_lo), .cs_n(cs_n), .bs_n(bs_n), .gpl(gpl), .busy(busy),
    .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  function automatic logic [3:0] exp_mask(input logic [1:0] ps,
                                          input logic [1:0] xs,
                                          input logic [1:0] al);
    logic [3:0] e;
    if (ps == 2'b00) begin
      if (xs == 2'b01)      e = (al == 2'd0) ? 4'h1 : (al == 2'd1) ? 4'h2 :
                                (al == 2'd2) ? 4'h4 : 4'h8;
      else if (xs == 2'b10) e = (al >= 2'd2) ? 4'hC : 4'h3;
      else                  e = 4'hF;
    end else if (ps == 2'b01) begin
      if (xs == 2'b01) e = (al == 2'd1 || al == 2'd3) ? 4'h8 : 4'h4;
      else             e = 4'hC;
    end else begin
      e = 4'h8;
    end
    return e;
  endfunction

  task automatic write_word(input logic [5:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    model[a] = d;
  endtask

  // Runs a sequence from sa and checks every phase against the model.
  // disturb: during word 0 / T2, try a write to sa+2 and a start, and change port_size.
  task automatic run_seq(input logic [5:0] sa, input logic [1:0] ps,
                         input logic [1:0] xs, input logic [1:0] al,
                         input bit disturb, input string req);
    logic [3:0] m;
    logic [5:0] a;
    logic [31:0] w;
    logic [1:0] code;
    bit fin;
    m = exp_mask(ps, xs, al);
    port_size = ps; xfer_size = xs; addr_lo = al;
    start = 1'b1; start_addr = sa;
    @(negedge clk);
    start = 1'b0;
    a = sa;
    fin = 1'b0;
    for (int n = 0; n < 64 && !fin; n++) begin
      w = model[a];
      for (int k = 0; k < 4; k++) begin
        code = (k < 2) ? w[9:8] : w[11:10];
        chk(req, "R7 busy", {31'd0, busy}, 32'd1);
        chk(req, "R2 cs_n", {31'd0, cs_n}, {31'd0, w[k]});
        chk(req, "R3 bs_n", {28'd0, bs_n}, {28'd0, (m & {4{w[4+k]}}) | ~m});
        chk(req, "R4 gpl", {31'd0, gpl},
            {31'd0, code[1] ? code[0] : gp_default});
        if (disturb && n == 0 && k == 1) begin
          host_we = 1'b1; host_addr = sa + 6'd2; host_wdata = 32'h8000_0000;
          start = 1'b1; start_addr = 6'd0; port_size = 2'b10;
          @(negedge clk);
          host_we = 1'b0; start = 1'b0;
        end else begin
          @(negedge clk);
        end
      end
      if (w[31]) fin = 1'b1;
      a = a + 6'd1;
    end
    chk(req, "R8 done", {31'd0, done}, 32'd1);
    chk(req, "R8 busy low", {31'd0, busy}, 32'd0);
    chk(req, "R8 idle cs_n", {31'd0, cs_n}, 32'd1);
    chk(req, "R8 idle bs_n", {28'd0, bs_n}, 32'hF);
    @(negedge clk);
    chk(req, "R8 done one clock", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "cs_n", {31'd0, cs_n}, 32'd1);
    chk("R1", "bs_n", {28'd0, bs_n}, 32'hF);
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "gpl", {31'd0, gpl}, 32'd0);
    gp_default = 1'b1;
    @(negedge clk);
    chk("R1", "idle gpl follows default", {31'd0, gpl}, 32'd1);
    gp_default = 1'b0;
    @(negedge clk);
    chk("R1", "idle gpl follows default low", {31'd0, gpl}, 32'd0);
  endtask

  task automatic t_cs_bs_gp();
    write_word(6'd0, 32'h0000_0E69);
    write_word(6'd1, 32'h0000_0400);
    write_word(6'd2, 32'h8000_03AF);
    gp_default = 1'b1;
    run_seq(6'd0, 2'b00, 2'b00, 2'b00, 1'b0, "R2_R4_dflt1");
    gp_default = 1'b0;
    run_seq(6'd0, 2'b00, 2'b11, 2'b00, 1'b0, "R2_R4_dflt0");
  endtask

  task automatic t_lanes();
    write_word(6'd20, 32'h8000_0A35);
    for (int p = 0; p < 3; p++) begin
      for (int x = 0; x < 4; x++) begin
        for (int l = 0; l < 4; l++) begin
          run_seq(6'd20, 2'(p), 2'(x), 2'(l), 1'b0, (p == 0) ? "R5" : "R6");
        end
      end
    end
    run_seq(6'd20, 2'b11, 2'b10, 2'b01, 1'b0, "R6");
  endtask

  task automatic t_wrap();
    write_word(6'd63, 32'h0000_0C0F);
    write_word(6'd0,  32'h8000_0150);
    gp_default = 1'b1;
    run_seq(6'd63, 2'b00, 2'b00, 2'b00, 1'b0, "R7");
    gp_default = 1'b0;
  endtask

  task automatic t_busy_ignore();
    write_word(6'd10, 32'h0000_0123);
    write_word(6'd11, 32'h0000_0456);
    write_word(6'd12, 32'h8000_0789);
    run_seq(6'd10, 2'b00, 2'b10, 2'b10, 1'b1, "R9");
    run_seq(6'd12, 2'b00, 2'b00, 2'b00, 1'b0, "R9");
    port_size = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    start = 1'b0; start_addr = '0; gp_default = 1'b0;
    port_size = 2'b00; xfer_size = 2'b00; addr_lo = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cs_bs_gp();
    t_lanes();
    t_wrap();
    t_busy_ignore();
    summary();
    $finish;
  end
endmodule